// File: doc/BRIEF.md
# Floating-Point Control and Status Register Unit

This block holds the 32-bit control and status word of a floating-point unit and makes it reachable through five control-register numbers. Number 31 shows the whole word. Numbers 25, 26 and 28 are repacked views of parts of it. Number 0 is a read-only implementation/revision constant. Each view writes back only the fields it owns. Reads are combinational. Writes take effect at the next clock edge.

The arithmetic pipeline reports each finished operation on a one-cycle strobe. The strobe carries six status bits: invalid, divide-by-zero, overflow, underflow, inexact and unimplemented. The block replaces the cause field with that status and accumulates it into the sticky flags. It raises a registered trap pulse when a cause is enabled or when the unimplemented cause is present. The rounding mode, the flush-to-zero control and the eight condition codes are driven to the rest of the FPU continuously.

Top module: `fpcs_unit`

## Requirements
- R1: After reset the status word is all zero: register 31 reads 0, the rounding mode is 0 (nearest-even), flush is 0, the condition codes are 0 and the trap is 0.
- R2: Register 0 reads the IMPL_REV parameter, and writes to it have no effect.
- R3: Register 31 shows the full word with this layout: rounding mode at 1:0, flags at 6:2, enables at 11:7, cause at 17:12, condition code 0 at bit 23, flush at bit 24, condition codes 7..1 at 31:25. Within flags, enables and cause the bit order is I, U, O, Z, V from the low end, and cause bit 5 (word bit 17) is E (unimplemented). Bits 22:18 read 0 and ignore writes.
- R4: Register 25 reads the condition codes with the gap closed: code 0 at bit 0, codes 7..1 at bits 7..1, and zeros above.
- R5: A write to register 25 changes only the condition-code bits (23 and 31:25) of the word, taking them from data bits 7:0.
- R6: Register 26 reads the word masked to cause and flags (bits 17:12 and 6:2). A write to it replaces only those fields.
- R7: Register 28 reads enables at 11:7, the rounding mode at 1:0 and the flush bit at bit 2. A write to it sets the enables, the rounding mode and flush (from data bit 2, with data bit 24 ignored), and keeps the condition codes, cause and flags.
- R8: The trap output pulses for one cycle, in the cycle after a write to register 26, 28 or 31. It pulses when the new word has cause AND enables nonzero, or cause E set. A write to register 25 never raises it.
- R9: An operation strobe clears the cause field and then sets V on invalid, Z on divide-by-zero, O on overflow, U on underflow, I on inexact and E on unimplemented. It raises the trap under the same condition as R8.
- R10: On an operation strobe, the new cause bits other than E are ORed into the sticky flags. Flags are never cleared by an operation.
- R11: The round_mode output (0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf), flush_zero and cond_codes (code 0 at bit 0) follow the word.
- R12: Read data is sign-extended from bit 31 to XLEN bits. Any register number other than 0, 25, 26, 28 and 31 reads 0 and ignores writes.
- R13: When a write and an operation strobe share a cycle, the write is merged first and the operation update is applied to the merged word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control-register write strobe |
| wr_addr | input | ADDR_W | Register number for the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Register number for the combinational read |
| rd_data | output | XLEN | Sign-extended read data |
| op_valid | input | 1 | One-cycle strobe for a completed FP operation |
| st_invalid | input | 1 | Operation raised an invalid condition |
| st_div0 | input | 1 | Operation divided by zero |
| st_overflow | input | 1 | Operation overflowed |
| st_underflow | input | 1 | Operation underflowed |
| st_inexact | input | 1 | Operation result was inexact |
| st_unimpl | input | 1 | Operation is unimplemented |
| round_mode | output | 2 | Current rounding mode |
| flush_zero | output | 1 | Flush denormal results to zero |
| cond_codes | output | 8 | Condition codes, code 0 at bit 0 |
| fp_trap | output | 1 | Registered floating-point exception pulse |

## Verification
Each alias view gets all-ones and sparse write patterns. Comparing register 31 afterwards shows whether the view leaked into fields it does not own or dropped one it does. The trap is driven in three ways: by a cause with and without a matching enable, by a lone unimplemented cause, and by a write to register 25 over a firing word. Together these separate the enable-gated path, the unconditional E path and the views that must not re-evaluate. Operation strobes run in a sequence whose cause changes from one strobe to the next, so a cause that is not cleared, or flags that are not sticky, give different words. A write and a strobe in the same cycle fix the order in which the two merge.

// File: rtl/fpcs_pkg.sv
package fpcs_pkg;

   // Control-register numbers that software addresses
   localparam int CR_IMPL = 0;
   localparam int CR_CC   = 25;
   localparam int CR_EXC  = 26;
   localparam int CR_ENA  = 28;
   localparam int CR_FULL = 31;

   localparam int CSR_W      = 32;
   localparam int NCC        = 8;
   localparam int EXC_W      = 5;   // I U O Z V
   localparam int CAU_W      = 6;   // I U O Z V E
   localparam int FLG_LO     = 2;
   localparam int ENA_LO     = 7;
   localparam int CAU_LO     = 12;
   localparam int CC0_POS    = 23;
   localparam int FLUSH_POS  = 24;
   localparam int CCH_LO     = 25;
   localparam int VIEW_FLUSH = 2;

   localparam logic [CSR_W-1:0] MASK_RM    = 32'h0000_0003;
   localparam logic [CSR_W-1:0] MASK_FLG   = 32'h0000_007C;
   localparam logic [CSR_W-1:0] MASK_ENA   = 32'h0000_0F80;
   localparam logic [CSR_W-1:0] MASK_CAU   = 32'h0003_F000;
   localparam logic [CSR_W-1:0] MASK_CC    = 32'hFE80_0000;
   localparam logic [CSR_W-1:0] MASK_FLUSH = 32'h0100_0000;
   localparam logic [CSR_W-1:0] MASK_LIVE  =
      MASK_RM | MASK_FLG | MASK_ENA | MASK_CAU | MASK_CC | MASK_FLUSH;

   typedef enum logic [1:0] {
      RND_NEAREST = 2'd0,
      RND_ZERO    = 2'd1,
      RND_UP      = 2'd2,
      RND_DOWN    = 2'd3
   } rnd_mode_e;

   // Trap condition: enabled cause present, or unimplemented cause present
   function automatic logic trap_cond(input logic [CSR_W-1:0] w);
      logic [CSR_W-1:0] cau;
      logic [CSR_W-1:0] ena;
      cau = (w & MASK_CAU) >> CAU_LO;
      ena = (w & MASK_ENA) >> ENA_LO;
      return ((cau & ena) != '0) || (cau[EXC_W] == 1'b1);
   endfunction

endpackage

// File: rtl/fpcs_read_view.sv
module fpcs_read_view
   import fpcs_pkg::*;
#(
   parameter int               XLEN     = 64,
   parameter int               ADDR_W   = 5,
   parameter logic [CSR_W-1:0] IMPL_REV = 32'h0000_0320
) (
   input  logic [CSR_W-1:0]  csr_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [XLEN-1:0]   data_o
);

   localparam int EXT_W = XLEN - CSR_W;

   logic [CSR_W-1:0] view;
   logic [NCC-1:0]   cc_packed;

   // Close the gap: code 0 goes to bit 0, codes 7..1 to bits 7..1
   assign cc_packed = {csr_i[CSR_W-1:CCH_LO], csr_i[CC0_POS]};

   always_comb begin
      view = '0;
      case (addr_i)
         ADDR_W'(CR_IMPL): view = IMPL_REV;
         ADDR_W'(CR_CC):   view = {{(CSR_W-NCC){1'b0}}, cc_packed};
         ADDR_W'(CR_EXC):  view = csr_i & (MASK_CAU | MASK_FLG);
         ADDR_W'(CR_ENA): begin
            view = csr_i & (MASK_ENA | MASK_RM);
            view[VIEW_FLUSH] = csr_i[FLUSH_POS];
         end
         ADDR_W'(CR_FULL): view = csr_i & MASK_LIVE;
         default:          view = '0;
      endcase
   end

   generate
      if (EXT_W > 0) begin : g_sext
         assign data_o = {{EXT_W{view[CSR_W-1]}}, view};
      end else begin : g_native
         assign data_o = view;
      end
   endgenerate

endmodule

// File: rtl/fpcs_write_merge.sv
module fpcs_write_merge
   import fpcs_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input  logic [CSR_W-1:0]  csr_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [CSR_W-1:0]  data_i,
   output logic [CSR_W-1:0]  csr_o,
   output logic              recheck_o
);

   logic [CSR_W-1:0] cc_spread;

   // Reopen the gap: bit 0 to code 0 position, bits 7..1 to the high codes
   always_comb begin
      cc_spread = '0;
      cc_spread[CC0_POS] = data_i[0];
      for (int k = 1; k < NCC; k++) begin
         cc_spread[CCH_LO + k - 1] = data_i[k];
      end
   end

   always_comb begin
      csr_o     = csr_i;
      recheck_o = 1'b0;
      if (wr_en_i) begin
         case (addr_i)
            ADDR_W'(CR_CC): begin
               csr_o = (csr_i & ~MASK_CC) | cc_spread;
            end
            ADDR_W'(CR_EXC): begin
               csr_o     = (csr_i & ~(MASK_CAU | MASK_FLG)) |
                           (data_i & (MASK_CAU | MASK_FLG));
               recheck_o = 1'b1;
            end
            ADDR_W'(CR_ENA): begin
               csr_o = (csr_i & (MASK_CC | MASK_CAU | MASK_FLG)) |
                       (data_i & (MASK_ENA | MASK_RM));
               csr_o[FLUSH_POS] = data_i[VIEW_FLUSH];
               recheck_o        = 1'b1;
            end
            ADDR_W'(CR_FULL): begin
               csr_o     = data_i & MASK_LIVE;
               recheck_o = 1'b1;
            end
            default: begin
               csr_o     = csr_i;
               recheck_o = 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/fpcs_op_update.sv
module fpcs_op_update
   import fpcs_pkg::*;
(
   input  logic [CSR_W-1:0] csr_i,
   input  logic             recheck_i,
   input  logic             op_valid_i,
   input  logic             invalid_i,
   input  logic             div0_i,
   input  logic             overflow_i,
   input  logic             underflow_i,
   input  logic             inexact_i,
   input  logic             unimpl_i,
   output logic [CSR_W-1:0] csr_o,
   output logic             trap_o
);

   logic [CAU_W-1:0] cause_new;
   logic [CSR_W-1:0] cause_word;
   logic [CSR_W-1:0] flag_word;

   // Cause order from bit 0: I U O Z V E
   assign cause_new = {unimpl_i, invalid_i, div0_i, overflow_i, underflow_i, inexact_i};

   always_comb begin
      cause_word = '0;
      flag_word  = '0;
      for (int k = 0; k < CAU_W; k++) begin
         cause_word[CAU_LO + k] = cause_new[k];
      end
      for (int k = 0; k < EXC_W; k++) begin
         flag_word[FLG_LO + k] = cause_new[k];
      end
   end

   always_comb begin
      csr_o = csr_i;
      if (op_valid_i) begin
         csr_o = (csr_i & ~MASK_CAU) | cause_word | flag_word;
      end
      trap_o = (op_valid_i || recheck_i) && trap_cond(csr_o);
   end

endmodule

// File: rtl/fpcs_unit.sv
module fpcs_unit
   import fpcs_pkg::*;
#(
   parameter int          XLEN     = 64,
   parameter int          ADDR_W   = 5,
   parameter logic [31:0] IMPL_REV = 32'h0000_0320
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [XLEN-1:0]   rd_data,
   input  logic              op_valid,
   input  logic              st_invalid,
   input  logic              st_div0,
   input  logic              st_overflow,
   input  logic              st_underflow,
   input  logic              st_inexact,
   input  logic              st_unimpl,
   output logic [1:0]        round_mode,
   output logic              flush_zero,
   output logic [7:0]        cond_codes,
   output logic              fp_trap
);

   if (!(XLEN == 32 || XLEN == 64)) begin : g_bad_xlen
      $error("fpcs_unit: XLEN must be 32 or 64");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("fpcs_unit: ADDR_W must be at least 5");
   end

   logic [CSR_W-1:0] csr_q;
   logic [CSR_W-1:0] csr_merged;
   logic [CSR_W-1:0] csr_next;
   logic             recheck;
   logic             trap_next;

   fpcs_write_merge #(.ADDR_W(ADDR_W)) u_merge (
      .csr_i     (csr_q),
      .wr_en_i   (wr_en),
      .addr_i    (wr_addr),
      .data_i    (wr_data),
      .csr_o     (csr_merged),
      .recheck_o (recheck)
   );

   fpcs_op_update u_update (
      .csr_i       (csr_merged),
      .recheck_i   (recheck),
      .op_valid_i  (op_valid),
      .invalid_i   (st_invalid),
      .div0_i      (st_div0),
      .overflow_i  (st_overflow),
      .underflow_i (st_underflow),
      .inexact_i   (st_inexact),
      .unimpl_i    (st_unimpl),
      .csr_o       (csr_next),
      .trap_o      (trap_next)
   );

   fpcs_read_view #(.XLEN(XLEN), .ADDR_W(ADDR_W), .IMPL_REV(IMPL_REV)) u_view (
      .csr_i  (csr_q),
      .addr_i (rd_addr),
      .data_o (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         csr_q   <= '0;
         fp_trap <= 1'b0;
      end else begin
         csr_q   <= csr_next;
         fp_trap <= trap_next;
      end
   end

   assign round_mode = csr_q[1:0];
   assign flush_zero = csr_q[FLUSH_POS];
   assign cond_codes = {csr_q[CSR_W-1:CCH_LO], csr_q[CC0_POS]};

   logic wr_defined;
   assign wr_defined = (wr_addr == ADDR_W'(CR_IMPL)) || (wr_addr == ADDR_W'(CR_CC))  ||
                       (wr_addr == ADDR_W'(CR_EXC))  || (wr_addr == ADDR_W'(CR_ENA)) ||
                       (wr_addr == ADDR_W'(CR_FULL));

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_q & ~MASK_LIVE) == '0);  // R3

   AST_TRAP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      fp_trap |-> trap_cond(csr_q));  // R8

   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !(wr_en && (wr_addr == ADDR_W'(CR_EXC) || wr_addr == ADDR_W'(CR_FULL))))
      |=> ((csr_q & $past(csr_q) & MASK_FLG) == ($past(csr_q) & MASK_FLG)));  // R10

   AST_CC_VIEW_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(CR_CC) && !op_valid)
      |=> ((csr_q & ~MASK_CC) == ($past(csr_q) & ~MASK_CC)));  // R5

   AST_ENA_VIEW_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(CR_ENA) && !op_valid)
      |=> ((csr_q & (MASK_CC | MASK_CAU | MASK_FLG)) ==
           ($past(csr_q) & (MASK_CC | MASK_CAU | MASK_FLG))));  // R7

   AST_UNDEF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (!wr_defined || wr_addr == ADDR_W'(CR_IMPL)) && !op_valid)
      |=> (csr_q == $past(csr_q)));  // R12

endmodule

// File: tb/fpcs_unit_tb.sv
module fpcs_unit_tb;

   localparam int          XLEN = 64;
   localparam int          AW   = 5;
   localparam logic [31:0] IMPL = 32'h8A01_0320;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [AW-1:0]   wr_addr = '0;
   logic [31:0]     wr_data = '0;
   logic [AW-1:0]   rd_addr = '0;
   logic [XLEN-1:0] rd_data;
   logic            op_valid = 1'b0;
   logic            st_invalid = 1'b0, st_div0 = 1'b0, st_overflow = 1'b0;
   logic            st_underflow = 1'b0, st_inexact = 1'b0, st_unimpl = 1'b0;
   logic [1:0]      round_mode;
   logic            flush_zero;
   logic [7:0]      cond_codes;
   logic            fp_trap;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   fpcs_unit #(.XLEN(XLEN), .ADDR_W(AW), .IMPL_REV(IMPL)) u_dut (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
      .op_valid, .st_invalid, .st_div0, .st_overflow, .st_underflow,
      .st_inexact, .st_unimpl, .round_mode, .flush_zero, .cond_codes, .fp_trap
   );

   function automatic logic [63:0] sx(input logic [31:0] v);
      return {{32{v[31]}}, v};
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic rd_check(input string req, input int addr, input logic [31:0] exp32);
      rd_addr = AW'(addr);
      #1;
      check(req, rd_data, sx(exp32));
   endtask

   task automatic clear_status();
      {st_invalid, st_div0, st_overflow, st_underflow, st_inexact, st_unimpl} = '0;
   endtask

   // Write, optional op strobe in the same cycle; returns at the following negedge
   task automatic cycle(input bit we, input int addr, input logic [31:0] data,
                        input bit ov, input logic [5:0] st);
      @(negedge clk);
      wr_en   = we;
      wr_addr = AW'(addr);
      wr_data = data;
      op_valid = ov;
      {st_unimpl, st_invalid, st_div0, st_overflow, st_underflow, st_inexact} = st;
      @(negedge clk);
      wr_en = 1'b0;
      op_valid = 1'b0;
      clear_status();
   endtask

   task automatic wr(input int addr, input logic [31:0] data);
      cycle(1'b1, addr, data, 1'b0, 6'b0);
   endtask

   // status order {E, V, Z, O, U, I}
   task automatic op(input logic [5:0] st);
      cycle(1'b0, 0, 32'h0, 1'b1, st);
   endtask

   task automatic t_reset();
      rd_check("R1 full word", 31, 32'h0);
      rd_check("R1 cc view", 25, 32'h0);
      check("R1 round_mode", 64'(round_mode), 64'd0);
      check("R1 flush", 64'(flush_zero), 64'd0);
      check("R1 cond_codes", 64'(cond_codes), 64'd0);
      check("R1 trap", 64'(fp_trap), 64'd0);
   endtask

   task automatic t_impl();
      rd_check("R2 R12 impl sign-extended", 0, IMPL);
      wr(0, 32'h1234_5678);
      rd_check("R2 impl unchanged", 0, IMPL);
      rd_check("R2 word untouched", 31, 32'h0);
   endtask

   task automatic t_full();
      wr(31, 32'hFFFF_FFFF);
      rd_check("R3 reserved zero", 31, 32'hFF83_FFFF);
      check("R8 trap on full write", 64'(fp_trap), 64'd1);
      check("R11 rm", 64'(round_mode), 64'd3);
      check("R11 flush", 64'(flush_zero), 64'd1);
      check("R11 cc", 64'(cond_codes), 64'hFF);
      wr(31, 32'h0);
      check("R8 trap cleared", 64'(fp_trap), 64'd0);
      rd_check("R3 cleared", 31, 32'h0);
   endtask

   task automatic t_cc_view();
      wr(31, 32'h0280_0003);
      rd_check("R4 gap closed", 25, 32'h0000_0003);
      wr(25, 32'h0000_0081);
      rd_check("R5 cc write", 31, 32'h8080_0003);
      check("R11 cond_codes", 64'(cond_codes), 64'h81);
      rd_check("R4 cc read back", 25, 32'h0000_0081);
      wr(25, 32'hFFFF_FF00);
      rd_check("R5 upper data ignored", 31, 32'h0000_0003);
   endtask

   task automatic t_exc_view();
      wr(31, 32'h0000_0F83);
      wr(26, 32'hFFFF_FFFF);
      rd_check("R6 merge", 31, 32'h0003_FFFF);
      check("R8 trap on exc write", 64'(fp_trap), 64'd1);
      rd_check("R6 view", 26, 32'h0003_F07C);
      wr(31, 32'h0);
      wr(26, 32'h0000_1000);
      check("R8 cause without enable", 64'(fp_trap), 64'd0);
      wr(28, 32'h0000_0080);
      check("R8 enable write fires", 64'(fp_trap), 64'd1);
      rd_check("R7 cause kept", 31, 32'h0000_1080);
      wr(25, 32'h0000_0001);
      check("R8 cc write no trap", 64'(fp_trap), 64'd0);
   endtask

   task automatic t_ena_view();
      wr(31, 32'h8180_007C);
      rd_check("R7 flush alias", 28, 32'h0000_0004);
      wr(28, 32'h0100_0F82);
      rd_check("R7 keep cc flags", 31, 32'h8080_0FFE);
      rd_check("R7 view", 28, 32'h0000_0F82);
      check("R7 flush from bit2", 64'(flush_zero), 64'd0);
      check("R11 rm toward +inf", 64'(round_mode), 64'd2);
      wr(28, 32'h0000_0004);
      rd_check("R7 flush set", 31, 32'h8180_007C);
      for (int m = 0; m < 4; m++) begin
         wr(28, 32'(m));
         check("R11 rm loop", 64'(round_mode), 64'(m));
      end
   endtask

   task automatic t_ops();
      wr(31, 32'h0);
      op(6'b010001);
      rd_check("R9 R10 V and I", 31, 32'h0001_1044);
      check("R9 no trap unenabled", 64'(fp_trap), 64'd0);
      op(6'b000100);
      rd_check("R9 cause replaced R10 sticky", 31, 32'h0000_4054);
      op(6'b100000);
      check("R9 E traps", 64'(fp_trap), 64'd1);
      rd_check("R10 E not sticky", 31, 32'h0002_0054);
      op(6'b000000);
      check("R9 trap drops", 64'(fp_trap), 64'd0);
      rd_check("R10 flags survive", 26, 32'h0000_0054);
      wr(31, 32'h0000_0400);
      op(6'b001000);
      rd_check("R9 Z cause", 31, 32'h0000_8420);
      check("R9 enabled trap", 64'(fp_trap), 64'd1);
   endtask

   task automatic t_undef();
      wr(31, 32'h0000_0003);
      wr(5, 32'hFFFF_FFFF);
      wr(30, 32'hFFFF_FFFF);
      rd_check("R12 undefined write ignored", 31, 32'h0000_0003);
      rd_check("R12 undefined reads zero", 5, 32'h0);
      rd_check("R12 undefined 27", 27, 32'h0);
   endtask

   task automatic t_same_cycle();
      wr(31, 32'h0);
      cycle(1'b1, 31, 32'h0000_0F80, 1'b1, 6'b000001);
      rd_check("R13 write then op", 31, 32'h0000_1F84);
      check("R13 trap", 64'(fp_trap), 64'd1);
      cycle(1'b1, 26, 32'h0000_8020, 1'b1, 6'b000000);
      rd_check("R13 op clears written cause", 31, 32'h0000_0FA0);
      check("R13 no trap", 64'(fp_trap), 64'd0);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_impl();
      t_full();
      t_cc_view();
      t_exc_view();
      t_ena_view();
      t_ops();
      t_undef();
      t_same_cycle();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule